// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo audio as a clock slave. A bit clock, a frame (left/right) clock and two serial data lines arrive from outside. The block brings all of them into its own system clock domain and detects the rising edges of the bit clock there. It counts bit slots from each frame-clock transition. It then shifts in the bits that fall inside the data window of the selected format and word length.

Configuration inputs select the framing, the word length and the bit-clock ratio. The framing is left-justified, right-justified or I2S. The word length is 16, 18 or 20 bits. The bit clock runs at 64 or 32 times the frame rate. Both data lines share the same clocks and are decoded in parallel. After every right channel completes, the block presents four sign-extended 20-bit words on one strobe: left and right for each line. An illegal configuration raises an error flag, and the strobe stays off while the flag is raised.

Top module: `serial_audio_rx`

## Requirements
- R1: With left-justified framing (fmt=00), the MSB sits in the first bit slot after a frame-clock transition and the left channel is the half where the frame clock is high. Word length is set by wlen: 00=16, 01=18, 10=20 bits. Output words are right-aligned and sign-extended to 20 bits.
- R2: With I2S framing (fmt=10), the MSB sits in the second bit slot after the transition, and the left channel is the half where the frame clock is low.
- R3: With right-justified framing (fmt=01) at ratio64=1, the LSB sits in the last (32nd) bit slot of each half, so capture starts in slot 32 minus the word length.
- R4: With ratio64=0, fmt=00 and wlen=00, halves are 16 bit slots long and 16-bit left-justified words are received correctly.
- R5: Both data inputs (sd_in[0] for ch0, sd_in[1] for ch1) are decoded at the same time under the same clocks, and each line's words are independent of the other.
- R6: config_error is high when fmt=11, when wlen=11, or when ratio64=0 with any mode other than fmt=00 and wlen=00. While it is high, no valid strobe is produced.
- R7: valid is a one-cycle pulse. If the bit-clock input rises, delivering the last bit of a right word, before system clock edge k, then valid is high in the cycle after edge k+2. All four outputs update at that same moment and hold their value between strobes.
- R8: After reset all outputs are zero and valid is low. No strobe comes until a left word and then a right word have been fully received after the first frame-clock transition seen on a bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | External bit clock, asynchronous |
| lrck_in | input | 1 | External frame clock, asynchronous |
| sd_in | input | 2 | Serial data lines, bit 0 feeds ch0, bit 1 feeds ch1 |
| fmt | input | 2 | Framing: 00 left-justified, 01 right-justified, 10 I2S |
| wlen | input | 2 | Word length: 00 16, 01 18, 10 20 bits |
| ratio64 | input | 1 | 1 selects 64 bit slots per frame, 0 selects 32 |
| ch0_left | output | 20 | Line 0 left word, sign-extended |
| ch0_right | output | 20 | Line 0 right word, sign-extended |
| ch1_left | output | 20 | Line 1 left word, sign-extended |
| ch1_right | output | 20 | Line 1 right word, sign-extended |
| valid | output | 1 | One-cycle strobe, new frame on all four words |
| config_error | output | 1 | Configuration is illegal |

## Verification
A slot counter that is off by one shows up as words that are shifted by one bit. Such words are visibly wrong on the first strobe after alignment, within one frame. A wrong channel polarity swaps left and right, or moves the strobe to the wrong half of the frame. Either error changes the cycle in which valid appears, so the cycle-exact strobe comparison catches it in the same frame. An extra or missing synchronizer stage moves every strobe by one system cycle and fails on the first frame.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int OW    = 20,
  parameter int SLOTS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_in,
  input  logic          lrck_in,
  input  logic [1:0]    sd_in,
  input  logic [1:0]    fmt,
  input  logic [1:0]    wlen,
  input  logic          ratio64,
  output logic [OW-1:0] ch0_left,
  output logic [OW-1:0] ch0_right,
  output logic [OW-1:0] ch1_left,
  output logic [OW-1:0] ch1_right,
  output logic          valid,
  output logic          config_error
);
  localparam int SW  = $clog2(SLOTS);
  localparam int SW1 = SW + 1;
  localparam logic [SW1-1:0] NSLOT = SW1'(SLOTS);
  localparam logic [SW-1:0]  TOP   = SW'(SLOTS - 1);

  logic [2:0] bq;
  logic [1:0] lq, dq0, dq1;
  logic rise, lr, b0, b1;
  logic seen, lr_prev, aligned, left_ok;
  logic [SW-1:0] slot, cur_slot;
  logic [SW1-1:0] wbits, start, last, cur_w;
  logic [OW-1:0] sh0, sh1, hold0, hold1, nx0, nx1, w0, w1;
  logic first, capture, done, is_left;

  function automatic logic [OW-1:0] sext(input logic [OW-1:0] x, input logic [SW1-1:0] n);
    logic signed [OW-1:0] t;
    t = signed'(x << (OW - int'(n)));
    return t >>> (OW - int'(n));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bq <= '0; lq <= '0; dq0 <= '0; dq1 <= '0;
    end else begin
      bq  <= {bq[1:0], bclk_in};
      lq  <= {lq[0], lrck_in};
      dq0 <= {dq0[0], sd_in[0]};
      dq1 <= {dq1[0], sd_in[1]};
    end
  end

  assign rise = bq[1] & ~bq[2];
  assign lr   = lq[1];
  assign b0   = dq0[1];
  assign b1   = dq1[1];

  assign config_error = (fmt == 2'b11) || (wlen == 2'b11) ||
                        (!ratio64 && (fmt != 2'b00 || wlen != 2'b00));

  assign first    = seen && (lr != lr_prev);
  assign cur_slot = first ? '0 : (slot == TOP) ? slot : slot + 1'b1;
  assign cur_w    = {1'b0, cur_slot};
  assign wbits    = (wlen == 2'b00) ? SW1'(16) : (wlen == 2'b01) ? SW1'(18) : SW1'(20);
  assign start    = (fmt == 2'b10) ? SW1'(1) : (fmt == 2'b01) ? NSLOT - wbits : '0;
  assign last     = start + wbits - 1'b1;
  assign capture  = rise && (aligned || first) && (cur_w >= start) && (cur_w <= last);
  assign done     = capture && (cur_w == last);
  assign is_left  = (fmt == 2'b10) ? ~lr : lr;
  assign nx0      = (cur_w == start) ? OW'(b0) : {sh0[OW-2:0], b0};
  assign nx1      = (cur_w == start) ? OW'(b1) : {sh1[OW-2:0], b1};
  assign w0       = sext(nx0, wbits);
  assign w1       = sext(nx1, wbits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; lr_prev <= 1'b0; aligned <= 1'b0; left_ok <= 1'b0;
      slot <= '0; sh0 <= '0; sh1 <= '0; hold0 <= '0; hold1 <= '0;
      ch0_left <= '0; ch0_right <= '0; ch1_left <= '0; ch1_right <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (rise) begin
        seen    <= 1'b1;
        lr_prev <= lr;
        slot    <= cur_slot;
        if (first) aligned <= 1'b1;
      end
      if (capture) begin
        sh0 <= nx0;
        sh1 <= nx1;
      end
      if (done) begin
        if (is_left) begin
          hold0   <= w0;
          hold1   <= w1;
          left_ok <= 1'b1;
        end else begin
          left_ok <= 1'b0;
          if (left_ok && !config_error) begin
            ch0_left  <= hold0;
            ch0_right <= w0;
            ch1_left  <= hold1;
            ch1_right <= w1;
            valid     <= 1'b1;
          end
        end
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  a_r6_no_strobe_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(!config_error));
  a_r7_follows_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(bq[1] && !bq[2]));
  a_r8_only_when_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> aligned);
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(ch0_left) && $stable(ch0_right) && $stable(ch1_left) && $stable(ch1_right)));
endmodule

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_in = 1'b0, lrck_in = 1'b0;
  logic [1:0] sd_in = 2'b00, fmt = 2'b00, wlen = 2'b00;
  logic ratio64 = 1'b1;
  logic [19:0] ch0_left, ch0_right, ch1_left, ch1_right;
  logic valid, config_error;

  int checks = 0, errors = 0, cyc = 0, vcyc = -1;
  logic [19:0] e0l, e0r, e1l, e1r;
  string tag = "R1";
  bit live = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrck_in(lrck_in), .sd_in(sd_in),
    .fmt(fmt), .wlen(wlen), .ratio64(ratio64),
    .ch0_left(ch0_left), .ch0_right(ch0_right), .ch1_left(ch1_left), .ch1_right(ch1_right),
    .valid(valid), .config_error(config_error));

  task automatic chk(input string t, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", t, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R7 valid timing", 20'(valid), 20'(cyc == vcyc));
      if (valid && cyc == vcyc) begin
        chk({tag, " ch0 left"}, ch0_left, e0l);
        chk({tag, " ch0 right"}, ch0_right, e0r);
        chk({tag, " R5 ch1 left"}, ch1_left, e1l);
        chk({tag, " R5 ch1 right"}, ch1_right, e1r);
      end
    end
  end

  function automatic int sx(input int v, input int n);
    return (v >= (1 << (n - 1))) ? v - (1 << n) : v;
  endfunction

  function automatic logic bitv(input int f, input int n, input int s, input int half,
                                input int smp, input logic junk);
    if (f == 0) return (s < n) ? smp[n-1-s] : junk;
    if (f == 2) return (s >= 1 && s <= n) ? smp[n-s] : junk;
    return (s >= half - n) ? smp[half-1-s] : junk;
  endfunction

  task automatic slot_out(input logic lr, input logic d0, input logic d1, input bit arm);
    bclk_in = 1'b0; lrck_in = lr; sd_in = {d1, d0};
    repeat (2) @(negedge clk);
    bclk_in = 1'b1;
    if (arm) vcyc = cyc + 3;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input string t, input int f, input int w, input bit r64,
                     input int nfr, input bit errexp);
    int n, half, lastslot;
    logic lft;
    n = (w == 0) ? 16 : (w == 1) ? 18 : 20;
    half = r64 ? 32 : 16;
    lastslot = (f == 0) ? n - 1 : (f == 2) ? n : half - 1;
    lft = (f == 2) ? 1'b0 : 1'b1;
    tag = t;
    live = 1'b0;
    @(negedge clk);
    fmt = 2'(f); wlen = 2'(w); ratio64 = r64; rst_n = 1'b0;
    bclk_in = 1'b0; lrck_in = ~lft;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset valid", 20'(valid), 20'(0));
    chk("R8 reset ch0_left", ch0_left, 20'(0));
    chk("R8 reset ch1_right", ch1_right, 20'(0));
    chk({"R6 config_error ", t}, 20'(config_error), 20'(errexp));
    live = 1'b1;
    for (int p = 0; p < 3; p++) slot_out(~lft, 1'($urandom), 1'($urandom), 1'b0);
    for (int fr = 0; fr < nfr; fr++) begin
      int l0, r0, l1, r1;
      l0 = int'($urandom) & ((1 << n) - 1);
      r0 = int'($urandom) & ((1 << n) - 1);
      l1 = int'($urandom) & ((1 << n) - 1);
      r1 = int'($urandom) & ((1 << n) - 1);
      if (fr == 0) begin l0 = 1 << (n - 1); r1 = (1 << (n - 1)) - 1; end
      for (int s = 0; s < half; s++)
        slot_out(lft, bitv(f, n, s, half, l0, 1'($urandom)), bitv(f, n, s, half, l1, 1'($urandom)), 1'b0);
      e0l = 20'(sx(l0, n)); e0r = 20'(sx(r0, n));
      e1l = 20'(sx(l1, n)); e1r = 20'(sx(r1, n));
      for (int s = 0; s < half; s++)
        slot_out(~lft, bitv(f, n, s, half, r0, 1'($urandom)), bitv(f, n, s, half, r1, 1'($urandom)),
                 !errexp && s == lastslot);
    end
    slot_out(lft, 1'b0, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    live = 1'b0;
  endtask

  initial begin
    run("R1 lj16", 0, 0, 1'b1, 3, 1'b0);
    run("R1 lj18", 0, 1, 1'b1, 3, 1'b0);
    run("R1 lj20", 0, 2, 1'b1, 3, 1'b0);
    run("R2 i2s16", 2, 0, 1'b1, 3, 1'b0);
    run("R2 i2s18", 2, 1, 1'b1, 3, 1'b0);
    run("R2 i2s20", 2, 2, 1'b1, 3, 1'b0);
    run("R3 rj16", 1, 0, 1'b1, 3, 1'b0);
    run("R3 rj18", 1, 1, 1'b1, 3, 1'b0);
    run("R3 rj20", 1, 2, 1'b1, 3, 1'b0);
    run("R4 lj16x32", 0, 0, 1'b0, 4, 1'b0);
    run("R6 fmt11", 3, 0, 1'b1, 2, 1'b1);
    run("R6 wlen11", 0, 3, 1'b1, 2, 1'b1);
    run("R6 i2s32", 2, 0, 1'b0, 2, 1'b1);
    run("R6 lj18x32", 0, 1, 1'b0, 2, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule